// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block paces auto-refresh for a two-bank SDRAM. A down-counter marks off a fixed number of clock cycles per refresh slot. Each slot that passes adds one refresh to a count of owed refreshes. For a 2048-row array refreshed over 32 ms, the slot length is 15.6 µs, which is 1560 cycles at 100 MHz. While refreshes are owed, the block raises a request toward the command sequencer.

The sequencer first closes both banks, then drives the auto-refresh command pattern: chip select, row strobe and column strobe low, write enable high, clock enable high. After that it pulses an acknowledge. Each accepted acknowledge pays off one owed refresh. It also moves an 11-bit row pointer forward, which mirrors the device's internal refresh row so coverage of the array can be checked.

The sequencer may postpone refreshes while traffic is heavy. The debt is bounded, and an urgent flag tells the sequencer to preempt traffic before the bound is reached. After every refresh the request is held off for a row-cycle time, so two refresh commands are never issued closer together than the device allows.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, the request and urgent outputs are 0, the owed count is 0 and the row pointer is 0.
- R2: The owed count rises by one at the end of every slot of INTERVAL_CYCLES clock cycles. The first increment lands on the INTERVAL_CYCLES-th rising edge after reset is released.
- R3: The owed count never exceeds MAX_OWED. A slot that ends while the count is already MAX_OWED leaves the count at MAX_OWED.
- R4: The request output is high exactly when the owed count is nonzero and no spacing hold-off is running.
- R5: The urgent output is high exactly when the owed count is at least URGENT_AT.
- R6: An acknowledge sampled while the request is high is accepted. It lowers the owed count by one and advances the row pointer by one. If a slot ends on the same edge, the owed count is left unchanged.
- R7: An acknowledge sampled while the request is low has no effect on the owed count or the row pointer.
- R8: After an accepted acknowledge, the request stays low for exactly TRC_CYCLES sampled cycles and then returns high if refreshes are still owed.
- R9: The row pointer counts accepted acknowledges modulo 2^ROW_BITS (2048 by default) and wraps from all-ones to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_ack | input | 1 | Pulse from the sequencer: auto-refresh issued with both banks closed |
| rfsh_req | output | 1 | Refresh wanted now |
| rfsh_urgent | output | 1 | Debt near its bound; sequencer must preempt traffic |
| owed_count | output | $clog2(MAX_OWED+1) | Number of refreshes owed |
| row_ptr | output | ROW_BITS | Next internal row that a refresh will cover |

## Verification
Every output comes from registers, so each result is due on the first rising edge after its cause. An acknowledge driven before edge k shows up in the owed count, the row pointer and the dropped request after edge k. A slot ending on edge k shows up as a higher count after edge k. The spacing hold-off keeps the request low through the next TRC_CYCLES samples.

The bench drives inputs on the falling edge and samples on the falling edge, just before it changes anything. It keeps its own count of edges since reset was released. This lets it place each check and each acknowledge on a known slot boundary, including an acknowledge that coincides with a slot end.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   // Width of a counter that must hold values 0..maxv
   function automatic int count_width(input int maxv);
      return (maxv < 1) ? 1 : $clog2(maxv + 1);
   endfunction

endpackage

// File: rtl/refsched_interval_timer.sv
module refsched_interval_timer #(
   parameter int INTERVAL_CYCLES = 1560
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = refsched_pkg::count_width(INTERVAL_CYCLES - 1);

   generate
      if (INTERVAL_CYCLES == 1) begin : g_every_cycle
         assign tick = rst_n;
      end else begin : g_countdown
         logic [CW-1:0] remain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               remain <= CW'(INTERVAL_CYCLES - 1);
            end else if (remain == '0) begin
               remain <= CW'(INTERVAL_CYCLES - 1);
            end else begin
               remain <= remain - CW'(1);
            end
         end
         assign tick = (remain == '0);
      end
   endgenerate
endmodule

// File: rtl/refsched_debt_counter.sv
module refsched_debt_counter #(
   parameter int MAX_OWED  = 8,
   parameter int URGENT_AT = 7,
   parameter int OWED_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              take,
   output logic [OWED_W-1:0] owed,
   output logic              has_debt,
   output logic              urgent
);
   logic [OWED_W-1:0] owed_nxt;
   logic              urgent_nxt;

   always_comb begin
      owed_nxt = owed;
      if (tick && !take) begin
         if (owed != OWED_W'(MAX_OWED)) owed_nxt = owed + OWED_W'(1);
      end else if (take && !tick) begin
         owed_nxt = owed - OWED_W'(1);
      end
      urgent_nxt = (owed_nxt >= OWED_W'(URGENT_AT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owed   <= '0;
         urgent <= 1'b0;
      end else begin
         owed   <= owed_nxt;
         urgent <= urgent_nxt;
      end
   end

   assign has_debt = (owed != '0);
endmodule

// File: rtl/refsched_spacing_timer.sv
module refsched_spacing_timer #(
   parameter int TRC_CYCLES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int SW = refsched_pkg::count_width(TRC_CYCLES);

   generate
      if (TRC_CYCLES == 0) begin : g_no_gap
         assign busy = 1'b0;
      end else begin : g_gap
         logic [SW-1:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold <= '0;
            end else if (start) begin
               hold <= SW'(TRC_CYCLES);
            end else if (hold != '0) begin
               hold <= hold - SW'(1);
            end
         end
         assign busy = (hold != '0);
      end
   endgenerate
endmodule

// File: rtl/refsched_row_tracker.sv
module refsched_row_tracker #(
   parameter int ROW_BITS = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   output logic [ROW_BITS-1:0] row
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row <= '0;
      else if (adv) row <= row + ROW_BITS'(1);
   end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
   parameter  int INTERVAL_CYCLES = 1560,
   parameter  int MAX_OWED        = 8,
   parameter  int URGENT_AT       = 7,
   parameter  int TRC_CYCLES      = 7,
   parameter  int ROW_BITS        = 11,
   localparam int OWED_W          = refsched_pkg::count_width(MAX_OWED)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rfsh_ack,
   output logic                rfsh_req,
   output logic                rfsh_urgent,
   output logic [OWED_W-1:0]   owed_count,
   output logic [ROW_BITS-1:0] row_ptr
);
   generate
      if (INTERVAL_CYCLES < 1) begin : g_bad_interval
         $error("INTERVAL_CYCLES must be at least 1");
      end
      if (MAX_OWED < 1) begin : g_bad_max
         $error("MAX_OWED must be at least 1");
      end
      if (URGENT_AT < 1 || URGENT_AT > MAX_OWED) begin : g_bad_urgent
         $error("URGENT_AT must lie in 1..MAX_OWED");
      end
      if (TRC_CYCLES < 0) begin : g_bad_trc
         $error("TRC_CYCLES must not be negative");
      end
      if (ROW_BITS < 1) begin : g_bad_rows
         $error("ROW_BITS must be at least 1");
      end
   endgenerate

   logic tick_w;
   logic take_w;
   logic debt_w;
   logic gap_w;

   assign take_w   = rfsh_ack & rfsh_req;
   assign rfsh_req = debt_w & ~gap_w;

   refsched_interval_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_w)
   );

   refsched_debt_counter #(
      .MAX_OWED (MAX_OWED),
      .URGENT_AT(URGENT_AT),
      .OWED_W   (OWED_W)
   ) u_debt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_w),
      .take    (take_w),
      .owed    (owed_count),
      .has_debt(debt_w),
      .urgent  (rfsh_urgent)
   );

   refsched_spacing_timer #(.TRC_CYCLES(TRC_CYCLES)) u_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .start(take_w),
      .busy (gap_w)
   );

   refsched_row_tracker #(.ROW_BITS(ROW_BITS)) u_rows (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (take_w),
      .row  (row_ptr)
   );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int MAX_OWED  = 8,
   parameter int URGENT_AT = 7,
   parameter int OWED_W    = 4,
   parameter int ROW_BITS  = 11
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rfsh_ack,
   input logic                rfsh_req,
   input logic                rfsh_urgent,
   input logic [OWED_W-1:0]   owed_count,
   input logic [ROW_BITS-1:0] row_ptr,
   input logic                tick
);
   p_bounded_debt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      owed_count <= OWED_W'(MAX_OWED));

   p_req_needs_debt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_req |-> (owed_count != '0));

   p_urgent_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rfsh_urgent) |-> ($past(owed_count) == OWED_W'(URGENT_AT - 1)));

   p_urgent_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rfsh_urgent) |-> (owed_count == OWED_W'(URGENT_AT - 1)));

   p_ack_pays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_ack && rfsh_req && !tick) |=> (owed_count == $past(owed_count) - OWED_W'(1)));

   p_ack_moves_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_ack && rfsh_req) |=> (row_ptr == $past(row_ptr) + ROW_BITS'(1)));

   p_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rfsh_req && !tick) |=> ($stable(owed_count) && $stable(row_ptr)));

   p_gap_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_ack && rfsh_req) |=> !rfsh_req);
endmodule

bind refresh_sched refresh_sched_chk #(
   .MAX_OWED (MAX_OWED),
   .URGENT_AT(URGENT_AT),
   .OWED_W   (OWED_W),
   .ROW_BITS (ROW_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rfsh_ack   (rfsh_ack),
   .rfsh_req   (rfsh_req),
   .rfsh_urgent(rfsh_urgent),
   .owed_count (owed_count),
   .row_ptr    (row_ptr),
   .tick       (tick_w)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
   localparam int INTERVAL = 10;
   localparam int MAXO     = 8;
   localparam int URG      = 7;
   localparam int TRC      = 3;
   localparam int RB       = 11;
   localparam int OW       = $clog2(MAXO + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ack;
   logic          req;
   logic          urgent;
   logic [OW-1:0] owed;
   logic [RB-1:0] row;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int acks   = 0;

   always #10 clk = ~clk;

   refresh_sched #(
      .INTERVAL_CYCLES(INTERVAL),
      .MAX_OWED       (MAXO),
      .URGENT_AT      (URG),
      .TRC_CYCLES     (TRC),
      .ROW_BITS       (RB)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rfsh_ack   (ack),
      .rfsh_req   (req),
      .rfsh_urgent(urgent),
      .owed_count (owed),
      .row_ptr    (row)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      cyc += n;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      step(1);
      ack = 1'b0;
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      ack   = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 req", int'(req), 0);
      chk("R1 urgent", int'(urgent), 0);
      chk("R1 owed", int'(owed), 0);
      chk("R1 row", int'(row), 0);
      rst_n = 1'b1;
      cyc   = 0;
   endtask

   task automatic test_accumulate();
      step(INTERVAL - 1);
      chk("R2 owed before first slot end", int'(owed), 0);
      chk("R4 req idle without debt", int'(req), 0);
      step(1);
      chk("R2 owed after first slot", int'(owed), 1);
      chk("R4 req with debt", int'(req), 1);
   endtask

   task automatic test_saturate();
      step(6 * INTERVAL - cyc);
      chk("R2 owed after six slots", int'(owed), 6);
      chk("R5 urgent below threshold", int'(urgent), 0);
      step(INTERVAL);
      chk("R2 owed after seven slots", int'(owed), 7);
      chk("R5 urgent at threshold", int'(urgent), 1);
      step(95 - cyc);
      chk("R3 owed saturated", int'(owed), MAXO);
      chk("R5 urgent when saturated", int'(urgent), 1);
   endtask

   task automatic test_ack_and_gap();
      pulse_ack();
      acks++;
      chk("R6 owed after ack", int'(owed), 7);
      chk("R6 row after ack", int'(row), 1);
      chk("R8 req low gap 1", int'(req), 0);
      step(1);
      chk("R8 req low gap 2", int'(req), 0);
      pulse_ack();
      chk("R7 owed unchanged by ack in gap", int'(owed), 7);
      chk("R7 row unchanged by ack in gap", int'(row), 1);
      chk("R8 req low gap 3", int'(req), 0);
      step(1);
      chk("R8 req back after gap", int'(req), 1);
      pulse_ack();
      acks++;
      chk("R6 owed with slot end and ack", int'(owed), 7);
      chk("R6 row with slot end and ack", int'(row), 2);
   endtask

   task automatic test_urgent_drop();
      step(TRC);
      chk("R4 req after second gap", int'(req), 1);
      pulse_ack();
      acks++;
      chk("R6 owed drained", int'(owed), 6);
      chk("R5 urgent cleared", int'(urgent), 0);
   endtask

   task automatic test_row_wrap();
      while (acks < (1 << RB) - 1) begin
         while (!req) step(1);
         pulse_ack();
         acks++;
      end
      chk("R9 row at top", int'(row), (1 << RB) - 1);
      while (!req) step(1);
      pulse_ack();
      acks++;
      chk("R9 row wrapped", int'(row), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      test_reset();
      test_accumulate();
      test_saturate();
      test_ack_and_gap();
      test_urgent_drop();
      test_row_wrap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule